// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This combinational block sits between a 32-bit integer datapath and a byte-addressable data memory that is one 32-bit word wide. On a load it takes the whole word that memory returned. It picks out the byte, the halfword or the full word that the effective address selects, then widens that value to the register width with sign or zero fill. On a store it copies the low byte or low halfword of the source register onto every lane of the same size. It also raises the byte-write enables for only the lanes that the address selects.

Lanes are numbered big-endian: the byte at the lowest address is the most significant byte of the word. Every access must be naturally aligned. A misaligned or malformed request sets an error output, blocks every write enable and forces the load result to zero. The effective address comes from elsewhere; only its low bits are decoded here.

Top module: `lsa_lane_aligner`

## Requirements
- R1: With size code 2'b00 (byte) and unsigned_i low, the load result is the addressed byte placed in bits 7:0, with bits 31:8 all equal to bit 7 of that byte.
- R2: With size code 2'b00 and unsigned_i high, the load result is the addressed byte placed in bits 7:0, with bits 31:8 zero.
- R3: Big-endian lane order: byte offset 0 is taken from bits 31:24 of the memory word, offset 1 from 23:16, offset 2 from 15:8 and offset 3 from 7:0.
- R4: With size code 2'b01 (halfword) and unsigned_i low, the load result's bits 15:8 hold the byte at offset A and bits 7:0 the byte at A+1, with bits 31:16 copies of bit 15.
- R5: With size code 2'b01 and unsigned_i high, the halfword is formed as in R4 and its upper 16 bits are zero.
- R6: With size code 2'b10 (word), the load result equals the memory word whatever unsigned_i is.
- R7: A byte store drives src_i[7:0] onto all four lanes. It raises exactly one write enable, bit (3 - offset), so offset 0 gives 4'b1000.
- R8: A halfword store drives src_i[15:0] onto both half lanes. Offset 0 gives enables 4'b1100 and offset 2 gives 4'b0011.
- R9: A word store drives src_i unchanged and raises enables 4'b1111.
- R10: A halfword at an odd offset, or a word at a nonzero offset, sets align_err_o. It drives all write enables low and forces the load result to zero.
- R11: Size code 2'b11 is reserved and is treated exactly like a misaligned request, as in R10.
- R12: While store_i is low the write enables are all zero, whatever the address and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 32 | Effective byte address; only the low 2 bits are decoded |
| size_i | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word, 11 reserved |
| unsigned_i | input | 1 | 1 selects zero fill on loads, 0 selects sign fill |
| store_i | input | 1 | 1 marks a store request and allows write enables |
| mem_rdata_i | input | 32 | Word returned by memory for a load |
| src_i | input | 32 | Register data to be stored |
| load_o | output | 32 | Aligned and extended load result |
| wdata_o | output | 32 | Store data replicated onto the lanes |
| wen_o | output | 4 | Byte-write enables, bit 3 is lane at offset 0 |
| align_err_o | output | 1 | Misaligned or reserved-size request |

## Verification
The hardest case to reach is telling big-endian lane order apart from an order that is mirrored but still self-consistent. A memory word with a single repeated byte, or a register value that is symmetric, hides a swapped lane. The stimulus therefore uses words whose four bytes are all distinct and have different top bits. It walks every offset for each size, with both fill modes, so that a swapped lane or a wrong fill bit changes the observed value. Misaligned offsets and the reserved size code are applied while store_i is high, so that a write enable that leaks past the error check would show at the port.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check #(
  parameter int unsigned OFF_W = 2
) (
  input  logic [OFF_W-1:0]       off_i,
  input  lsa_pkg::xfer_size_e    size_i,
  output logic                   misalign_o,
  output logic                   size_bad_o
);
  import lsa_pkg::*;

  always_comb begin
    misalign_o = 1'b0;
    size_bad_o = 1'b0;
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = off_i[0];
      SZ_WORD: misalign_o = (off_i != '0);
      default: size_bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]          mem_word_i,
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  lsa_pkg::xfer_size_e        size_i,
  input  logic                       zero_fill_i,
  input  logic                       fault_i,
  output logic [DATA_W-1:0]          result_o
);
  import lsa_pkg::*;

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned HALVES = LANES / 2;
  localparam int unsigned OFF_W = $clog2(LANES);

  logic [7:0]  lane_b [LANES];
  logic [15:0] lane_h [HALVES];
  logic [7:0]  pick_b;
  logic [15:0] pick_h;

  for (genvar g = 0; g < LANES; g++) begin : g_byte_lane
    assign lane_b[g] = mem_word_i[DATA_W-1-8*g -: 8];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half_lane
    assign lane_h[h] = {lane_b[2*h], lane_b[2*h+1]};
  end

  assign pick_b = lane_b[off_i];
  assign pick_h = lane_h[off_i[OFF_W-1:1]];

  function automatic logic [DATA_W-1:0] widen_byte(input logic [7:0] b, input logic zf);
    logic fill;
    fill = zf ? 1'b0 : b[7];
    return {{(DATA_W-8){fill}}, b};
  endfunction

  function automatic logic [DATA_W-1:0] widen_half(input logic [15:0] hw, input logic zf);
    logic fill;
    fill = zf ? 1'b0 : hw[15];
    return {{(DATA_W-16){fill}}, hw};
  endfunction

  always_comb begin
    result_o = '0;
    if (!fault_i) begin
      unique case (size_i)
        SZ_BYTE: result_o = widen_byte(pick_b, zero_fill_i);
        SZ_HALF: result_o = widen_half(pick_h, zero_fill_i);
        SZ_WORD: result_o = mem_word_i;
        default: result_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/lsa_store_replicate.sv
module lsa_store_replicate #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]           src_i,
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  lsa_pkg::xfer_size_e         size_i,
  input  logic                        store_i,
  input  logic                        fault_i,
  output logic [DATA_W-1:0]           wdata_o,
  output logic [DATA_W/8-1:0]         wen_o
);
  import lsa_pkg::*;

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned HALVES = LANES / 2;

  logic [LANES-1:0] mask;

  function automatic logic [LANES-1:0] lane_mask(input xfer_size_e sz, input int unsigned off);
    logic [LANES-1:0] m;
    m = '0;
    unique case (sz)
      SZ_BYTE: m = LANES'(1) << (LANES - 1 - off);
      SZ_HALF: m = LANES'(3) << (LANES - 2 - off);
      SZ_WORD: m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  always_comb begin
    unique case (size_i)
      SZ_BYTE: wdata_o = {LANES{src_i[7:0]}};
      SZ_HALF: wdata_o = {HALVES{src_i[15:0]}};
      default: wdata_o = src_i;
    endcase
  end

  assign mask  = lane_mask(size_i, int'(off_i));
  assign wen_o = (store_i && !fault_i) ? mask : '0;
endmodule

// File: rtl/lsa_lane_aligner.sv
module lsa_lane_aligner #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          size_i,
  input  logic                unsigned_i,
  input  logic                store_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic [DATA_W-1:0]   src_i,
  output logic [DATA_W-1:0]   load_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [DATA_W/8-1:0] wen_o,
  output logic                align_err_o
);
  import lsa_pkg::*;

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(LANES);

  xfer_size_e       size_w;
  logic [OFF_W-1:0] off_w;
  logic             misalign_w;
  logic             size_bad_w;
  logic             fault_w;

  assign size_w  = xfer_size_e'(size_i);
  assign off_w   = addr_i[OFF_W-1:0];
  assign fault_w = misalign_w | size_bad_w;

  lsa_align_check #(.OFF_W(OFF_W)) u_align (
    .off_i      (off_w),
    .size_i     (size_w),
    .misalign_o (misalign_w),
    .size_bad_o (size_bad_w)
  );

  lsa_load_extract #(.DATA_W(DATA_W)) u_load (
    .mem_word_i  (mem_rdata_i),
    .off_i       (off_w),
    .size_i      (size_w),
    .zero_fill_i (unsigned_i),
    .fault_i     (fault_w),
    .result_o    (load_o)
  );

  lsa_store_replicate #(.DATA_W(DATA_W)) u_store (
    .src_i   (src_i),
    .off_i   (off_w),
    .size_i  (size_w),
    .store_i (store_i),
    .fault_i (fault_w),
    .wdata_o (wdata_o),
    .wen_o   (wen_o)
  );

  assign align_err_o = fault_w;
endmodule

// File: rtl/lsa_lane_aligner_chk.sv
module lsa_lane_aligner_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input logic [ADDR_W-1:0]   addr_i,
  input logic [1:0]          size_i,
  input logic                unsigned_i,
  input logic                store_i,
  input logic [DATA_W-1:0]   load_o,
  input logic [DATA_W/8-1:0] wen_o,
  input logic                align_err_o
);
  always_comb begin
    // R10/R11: an error never lets a write through
    p_err_blocks_wen_r10: assert (!align_err_o || wen_o == '0)
      else $error("write enable during alignment error");
    p_err_zero_load_r10: assert (!align_err_o || load_o == '0)
      else $error("nonzero load during alignment error");
    p_rsvd_flags_r11: assert (size_i != 2'b11 || align_err_o)
      else $error("reserved size not flagged");
    p_no_store_no_wen_r12: assert (store_i || wen_o == '0)
      else $error("write enable without store");
    p_byte_onehot_r7: assert (!(store_i && size_i == 2'b00) || $countones(wen_o) == 1)
      else $error("byte store enable not one-hot");
    p_half_two_r8: assert (!(store_i && size_i == 2'b01 && !addr_i[0]) || $countones(wen_o) == 2)
      else $error("halfword store enable count");
    p_ubyte_zero_r2: assert (!(size_i == 2'b00 && unsigned_i) || load_o[DATA_W-1:8] == '0)
      else $error("unsigned byte upper bits not zero");
    p_sbyte_fill_r1: assert (!(size_i == 2'b00 && !unsigned_i) ||
                             load_o[DATA_W-1:8] == {(DATA_W-8){load_o[7]}})
      else $error("signed byte fill wrong");
  end
endmodule

bind lsa_lane_aligner lsa_lane_aligner_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .addr_i      (addr_i),
  .size_i      (size_i),
  .unsigned_i  (unsigned_i),
  .store_i     (store_i),
  .load_o      (load_o),
  .wen_o       (wen_o),
  .align_err_o (align_err_o)
);

// File: tb/lsa_lane_aligner_tb.sv
`timescale 1ns/1ps
module lsa_lane_aligner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr;
  logic [1:0]  size;
  logic        uns;
  logic        st;
  logic [31:0] mem;
  logic [31:0] src;
  logic [31:0] load_o;
  logic [31:0] wdata_o;
  logic [3:0]  wen_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lsa_lane_aligner u_dut (
    .addr_i(addr), .size_i(size), .unsigned_i(uns), .store_i(st),
    .mem_rdata_i(mem), .src_i(src), .load_o(load_o), .wdata_o(wdata_o),
    .wen_o(wen_o), .align_err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] sz, input logic u,
                       input logic s, input logic [31:0] m, input logic [31:0] d);
    @(negedge clk);
    addr = a; size = sz; uns = u; st = s; mem = m; src = d;
    #1;
  endtask

  // byte k of a word, k=0 is the lowest address (most significant)
  function automatic logic [7:0] mbyte(input logic [31:0] w, input int k);
    return w[8*(3-k) +: 8];
  endfunction

  task automatic t_idle();
    apply(32'h0, 2'b10, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R12 idle wen", {28'h0, wen_o}, 32'h0);
    check("R10 idle err", {31'h0, err_o}, 32'h0);
  endtask

  task automatic t_byte_loads(input logic [31:0] m);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = mbyte(m, k);
      apply(32'h1000 + k, 2'b00, 1'b0, 1'b0, m, 32'h0);
      check("R1 R3 signed byte", load_o, {{24{b[7]}}, b});
      apply(32'h1000 + k, 2'b00, 1'b1, 1'b0, m, 32'h0);
      check("R2 R3 unsigned byte", load_o, {24'h0, b});
    end
  endtask

  task automatic t_half_loads(input logic [31:0] m);
    for (int k = 0; k < 4; k += 2) begin
      logic [15:0] hw;
      hw = {mbyte(m, k), mbyte(m, k + 1)};
      apply(32'h2000 + k, 2'b01, 1'b0, 1'b0, m, 32'h0);
      check("R4 signed half", load_o, {{16{hw[15]}}, hw});
      apply(32'h2000 + k, 2'b01, 1'b1, 1'b0, m, 32'h0);
      check("R5 unsigned half", load_o, {16'h0, hw});
    end
  endtask

  task automatic t_word_loads(input logic [31:0] m);
    apply(32'h3000, 2'b10, 1'b0, 1'b0, m, 32'h0);
    check("R6 word signed", load_o, m);
    apply(32'h3000, 2'b10, 1'b1, 1'b0, m, 32'h0);
    check("R6 word unsigned", load_o, m);
  endtask

  task automatic t_stores(input logic [31:0] d);
    for (int k = 0; k < 4; k++) begin
      apply(32'h4000 + k, 2'b00, 1'b0, 1'b1, 32'h0, d);
      check("R7 byte data", wdata_o, {4{d[7:0]}});
      check("R7 byte wen", {28'h0, wen_o}, {28'h0, 4'b1000 >> k});
    end
    apply(32'h4000, 2'b01, 1'b0, 1'b1, 32'h0, d);
    check("R8 half data", wdata_o, {2{d[15:0]}});
    check("R8 half wen off0", {28'h0, wen_o}, 32'hC);
    apply(32'h4002, 2'b01, 1'b0, 1'b1, 32'h0, d);
    check("R8 half wen off2", {28'h0, wen_o}, 32'h3);
    apply(32'h4000, 2'b10, 1'b0, 1'b1, 32'h0, d);
    check("R9 word data", wdata_o, d);
    check("R9 word wen", {28'h0, wen_o}, 32'hF);
  endtask

  task automatic t_misalign(input logic [31:0] m);
    for (int k = 1; k < 4; k += 2) begin
      apply(32'h5000 + k, 2'b01, 1'b0, 1'b1, m, 32'hFFFF_FFFF);
      check("R10 half odd err", {31'h0, err_o}, 32'h1);
      check("R10 half odd wen", {28'h0, wen_o}, 32'h0);
      check("R10 half odd load", load_o, 32'h0);
    end
    for (int k = 1; k < 4; k++) begin
      apply(32'h5000 + k, 2'b10, 1'b0, 1'b1, m, 32'hFFFF_FFFF);
      check("R10 word off err", {31'h0, err_o}, 32'h1);
      check("R10 word off wen", {28'h0, wen_o}, 32'h0);
      check("R10 word off load", load_o, 32'h0);
    end
    apply(32'h5001, 2'b00, 1'b0, 1'b1, m, 32'h0);
    check("R10 byte never misaligned", {31'h0, err_o}, 32'h0);
  endtask

  task automatic t_reserved(input logic [31:0] m);
    apply(32'h6000, 2'b11, 1'b0, 1'b1, m, 32'h1234_5678);
    check("R11 rsvd err", {31'h0, err_o}, 32'h1);
    check("R11 rsvd wen", {28'h0, wen_o}, 32'h0);
    check("R11 rsvd load", load_o, 32'h0);
  endtask

  task automatic t_no_store(input logic [31:0] d);
    for (int s = 0; s < 3; s++) begin
      apply(32'h7000, 2'(s), 1'b0, 1'b0, 32'h0, d);
      check("R12 no store wen", {28'h0, wen_o}, 32'h0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    addr = '0; size = 2'b10; uns = 1'b0; st = 1'b0; mem = '0; src = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_byte_loads(32'h81_42_C3_24);
    t_byte_loads(32'h7F_80_01_FE);
    t_half_loads(32'h81_42_C3_24);
    t_half_loads(32'h12_F3_A5_06);
    t_word_loads(32'h8000_00FF);
    t_stores(32'hA1B2_C3D4);
    t_stores(32'h0000_5A7E);
    t_misalign(32'hDEAD_BEEF);
    t_reserved(32'hDEAD_BEEF);
    t_no_store(32'hCAFE_F00D);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule